// File: doc/BRIEF.md
# Watermark-Gated Receive Frame Admission

This block sits in a receive path. For each incoming frame it decides whether the frame is admitted or discarded, and it bases that decision on how many receive buffers remain free. When the number of free buffers is normal, every frame is admitted. Once the free count falls to a programmed low level, the block admits only a programmed number of further good frames. After that it sheds every new frame until the free count climbs back to a programmed high level. The gap between the two levels gives the block hysteresis, so it does not toggle between admitting and shedding on every small change in the free count.

The verdict for a frame is taken when the frame starts, and it holds until the frame ends. A frame is never cut off partway. Each shed frame produces a single-cycle pulse, which a statistics counter elsewhere can count. A level output shows when the block is shedding.

The block is built around three states:
- `ST_ADMIT`: normal operation. The allowance counter follows the programmed value.
- `ST_RATION`: the low level has been reached. Good frames use up the allowance.
- `ST_SHED`: the allowance is used up. Every new frame is dropped.

It has five named transitions:
- `LOW_SPEND` takes `ST_ADMIT` to `ST_RATION` when the low level is hit and the allowance is not zero.
- `LOW_ZERO` takes `ST_ADMIT` to `ST_SHED` when the low level is hit and the allowance is zero.
- `EXHAUST` takes `ST_RATION` to `ST_SHED` when the last unit of the allowance is used.
- `RECOVER_R` takes `ST_RATION` back to `ST_ADMIT` when the free count reaches the effective high level.
- `RECOVER_S` takes `ST_SHED` back to `ST_ADMIT` when the free count reaches the effective high level.

Top module: `rx_admit_gate`

## Requirements
- R1: A synchronous active-low reset puts the block in `ST_ADMIT`, with `frm_pass_o`, `frm_drop_o` and `drop_active_o` all low.
- R2: A frame is admitted when its start (`sof_i` high while no frame is open) is sampled in `ST_ADMIT` or `ST_RATION`. While the frame is admitted, `frm_pass_o` is high from the cycle after the start through the cycle in which `eof_i` is sampled.
- R3: The low level is hit when the free count is less than or equal to the low level. In `ST_ADMIT`, this moves the block to `ST_RATION` on the next edge if the allowance is non-zero, and to `ST_SHED` if the allowance is zero (the reset value of a zeroed allowance register).
- R4: In `ST_RATION`, each end (`eof_i`) of an admitted open frame with `good_i` high uses one unit of the allowance. The edge that uses the last unit moves the block to `ST_SHED`.
- R5: An end with `good_i` low uses no allowance. The allowance counter saturates at zero.
- R6: A frame whose start is sampled in `ST_SHED` is dropped. `frm_drop_o` pulses for exactly the one cycle after the start, and `frm_pass_o` stays low for the whole frame.
- R7: In `ST_RATION` or `ST_SHED`, a free count greater than or equal to the effective high level returns the block to `ST_ADMIT` on the next edge. This recovery has priority over `EXHAUST`. The allowance is reloaded from the programmed value while the block is in `ST_ADMIT`.
- R8: If the high level is programmed at or below the low level, the low level is used as the effective high level.
- R9: The verdict is held for the whole frame. A state change during an open frame does not change `frm_pass_o` for that frame.
- R10: `sof_i` is ignored while a frame is open. `eof_i` is ignored while no frame is open, and it is also ignored in the same cycle as the start that opens a frame.
- R11: `drop_active_o` is high exactly while the block is in `ST_SHED`. It changes on the edge that enters or leaves that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| free_bufs_i | input | FREE_W | Current count of free receive buffers |
| low_mark_i | input | FREE_W | Low level (threshold for the low condition) |
| high_mark_i | input | FREE_W | High level (threshold for recovery) |
| allow_i | input | ALLOW_W | Number of good frames admitted after the low level is hit |
| sof_i | input | 1 | Frame start strobe |
| eof_i | input | 1 | Frame end strobe |
| good_i | input | 1 | Frame status, sampled with `eof_i`; high means a good frame |
| frm_pass_o | output | 1 | High while an admitted frame is open |
| frm_drop_o | output | 1 | One-cycle pulse for each dropped frame |
| drop_active_o | output | 1 | High while the block is in `ST_SHED` |

## Verification
The bench builds the block with `FREE_W` = 6 and the default 16-bit allowance. A 6-bit free count puts both ends of the range (0 and 63) and every equality boundary against the two levels within a few lines of stimulus. The bench uses allowances of 0, 1, 2 and 3, so `LOW_ZERO`, single-frame and multi-frame exhaustion each occur. The full-width allowance value 16'hFFFF is used to confirm that a large allowance never exhausts during a short run. A case with the high level below the low level exercises the fallback to the low level as the effective high level. Frames are held open across state changes to show that a verdict is kept for the whole frame.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

    typedef enum logic [1:0] {
        ST_ADMIT  = 2'd0,
        ST_RATION = 2'd1,
        ST_SHED   = 2'd2
    } rxa_state_e;

endpackage

// File: rtl/rxa_level_cmp.sv
module rxa_level_cmp #(
    parameter int FREE_W = 10
) (
    input  logic [FREE_W-1:0] free_i,
    input  logic [FREE_W-1:0] low_i,
    input  logic [FREE_W-1:0] high_i,
    output logic              low_hit_o,
    output logic              high_hit_o
);

    logic [FREE_W-1:0] high_eff;

    // A high level at or below the low level falls back to the low level (R8)
    always_comb begin
        high_eff   = (high_i > low_i) ? high_i : low_i;
        low_hit_o  = (free_i <= low_i);
        high_hit_o = (free_i >= high_eff);
    end

endmodule

// File: rtl/rxa_allow_ctr.sv
module rxa_allow_ctr #(
    parameter int ALLOW_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [ALLOW_W-1:0] load_val_i,
    input  logic               dec_i,
    output logic               zero_o,
    output logic               one_o
);

    localparam logic [ALLOW_W-1:0] CNT_ONE = ALLOW_W'(1);

    logic [ALLOW_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    always_comb begin
        zero_o = (cnt_q == '0);
        one_o  = (cnt_q == CNT_ONE);
    end

    // R5: the counter never wraps below zero
    a_r5_ctr_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));

    // R4: each accepted decrement lowers the count by exactly one
    a_r4_ctr_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && dec_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

endmodule

// File: rtl/rxa_fsm.sv
module rxa_fsm
    import rxa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       low_hit_i,
    input  logic       high_hit_i,
    input  logic       allow_zero_i,
    input  logic       spent_i,
    output rxa_state_e state_o,
    output logic       reload_o,
    output logic       ration_o,
    output logic       shed_o
);

    rxa_state_e state_q;
    rxa_state_e state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ADMIT;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_ADMIT: begin
                if (low_hit_i) begin
                    state_n = allow_zero_i ? ST_SHED : ST_RATION;   // LOW_ZERO / LOW_SPEND
                end
            end
            ST_RATION: begin
                if (high_hit_i) begin
                    state_n = ST_ADMIT;                             // RECOVER_R
                end else if (spent_i) begin
                    state_n = ST_SHED;                              // EXHAUST
                end
            end
            ST_SHED: begin
                if (high_hit_i) begin
                    state_n = ST_ADMIT;                             // RECOVER_S
                end
            end
            default: state_n = ST_ADMIT;
        endcase
    end

    always_comb begin
        reload_o = 1'b0;
        ration_o = 1'b0;
        shed_o   = 1'b0;
        unique case (state_q)
            ST_ADMIT:  reload_o = 1'b1;
            ST_RATION: ration_o = 1'b1;
            ST_SHED:   shed_o   = 1'b1;
            default:   reload_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    // R7: the shedding state is only left when the high level has been reached
    a_r7_shed_exit_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SHED && state_q != ST_SHED) |-> $past(high_hit_i));

    // R3: the rationing state is only entered from normal operation on a low hit
    a_r3_ration_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_RATION && state_q == ST_RATION) |->
            ($past(state_q) == ST_ADMIT && $past(low_hit_i) && !$past(allow_zero_i)));

    // R7: recovery never goes straight from rationing to shedding
    a_r7_recover_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RATION && high_hit_i) |=> (state_q == ST_ADMIT));

endmodule

// File: rtl/rxa_frame_track.sv
module rxa_frame_track (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_i,
    input  logic eof_i,
    input  logic good_i,
    input  logic admit_i,
    output logic pass_o,
    output logic drop_pulse_o,
    output logic good_end_o
);

    logic open_q;
    logic kept_q;
    logic drop_q;
    logic start_ev;
    logic end_ev;

    always_comb begin
        start_ev   = sof_i && !open_q;      // R10: starts inside an open frame are ignored
        end_ev     = eof_i && open_q;       // R10: ends without an open frame are ignored
        good_end_o = end_ev && kept_q && good_i;
        pass_o     = open_q && kept_q;
        drop_pulse_o = drop_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            kept_q <= 1'b0;
            drop_q <= 1'b0;
        end else begin
            drop_q <= start_ev && !admit_i;
            if (start_ev) begin
                open_q <= 1'b1;
                kept_q <= admit_i;
            end else if (end_ev) begin
                open_q <= 1'b0;
                kept_q <= 1'b0;
            end
        end
    end

    // R9: a verdict does not change while its frame stays open
    a_r9_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && !eof_i) |=> (open_q && $stable(kept_q)));

    // R6: a drop pulse only follows a start that opened a frame
    a_r6_drop_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse_o |-> ($past(sof_i) && !$past(open_q)));

    // R6: a drop pulse lasts a single cycle
    a_r6_drop_single: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse_o |=> !drop_pulse_o);

endmodule

// File: rtl/rx_admit_gate.sv
module rx_admit_gate
    import rxa_pkg::*;
#(
    parameter int FREE_W  = 10,
    parameter int ALLOW_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FREE_W-1:0]  free_bufs_i,
    input  logic [FREE_W-1:0]  low_mark_i,
    input  logic [FREE_W-1:0]  high_mark_i,
    input  logic [ALLOW_W-1:0] allow_i,
    input  logic               sof_i,
    input  logic               eof_i,
    input  logic               good_i,
    output logic               frm_pass_o,
    output logic               frm_drop_o,
    output logic               drop_active_o
);

    logic       low_hit;
    logic       high_hit;
    logic       cnt_zero;
    logic       cnt_one;
    logic       reload;
    logic       ration;
    logic       shed;
    logic       good_end;
    logic       spend;
    logic       spent;
    logic       allow_zero;
    rxa_state_e state;

    rxa_level_cmp #(.FREE_W(FREE_W)) u_cmp (
        .free_i     (free_bufs_i),
        .low_i      (low_mark_i),
        .high_i     (high_mark_i),
        .low_hit_o  (low_hit),
        .high_hit_o (high_hit)
    );

    always_comb begin
        allow_zero = (allow_i == '0);
        spend      = ration && good_end;
        spent      = cnt_zero || (spend && cnt_one);
    end

    rxa_allow_ctr #(.ALLOW_W(ALLOW_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (reload),
        .load_val_i (allow_i),
        .dec_i      (spend),
        .zero_o     (cnt_zero),
        .one_o      (cnt_one)
    );

    rxa_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .low_hit_i    (low_hit),
        .high_hit_i   (high_hit),
        .allow_zero_i (allow_zero),
        .spent_i      (spent),
        .state_o      (state),
        .reload_o     (reload),
        .ration_o     (ration),
        .shed_o       (shed)
    );

    rxa_frame_track u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .sof_i        (sof_i),
        .eof_i        (eof_i),
        .good_i       (good_i),
        .admit_i      (!shed),
        .pass_o       (frm_pass_o),
        .drop_pulse_o (frm_drop_o),
        .good_end_o   (good_end)
    );

    assign drop_active_o = shed;

    // R11: a dropped frame always started while shedding was signalled
    a_r11_drop_in_shed: assert property (@(posedge clk) disable iff (!rst_n)
        frm_drop_o |-> $past(drop_active_o));

    // R2: an admitted frame never opens while shedding was signalled
    a_r2_pass_not_from_shed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_pass_o) |-> !$past(drop_active_o));

    // R8: both level flags agree only at the low level itself
    a_r8_flags_meet_at_low: assert property (@(posedge clk) disable iff (!rst_n)
        (low_hit && high_hit) |-> (free_bufs_i == low_mark_i));

    // R6: admitting and dropping are never signalled together
    a_r6_pass_drop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_pass_o && frm_drop_o));

    // R4: the exhaust edge leads straight to shedding
    a_r4_exhaust_to_shed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RATION && !high_hit && spend && cnt_one) |=> drop_active_o);

endmodule

// File: tb/rx_admit_gate_tb.sv
`timescale 1ns/1ps
module rx_admit_gate_tb;

    localparam int FW = 6;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] free_bufs = 6'd40;
    logic [FW-1:0] low_mark = 6'd8;
    logic [FW-1:0] high_mark = 6'd20;
    logic [AW-1:0] allow = '0;
    logic          sof = 1'b0;
    logic          eof = 1'b0;
    logic          good = 1'b0;
    logic          frm_pass;
    logic          frm_drop;
    logic          drop_active;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state: 0 admit, 1 ration, 2 shed
    int m_st = 0;
    int m_cnt = 0;
    bit m_open = 0;
    bit m_kept = 0;
    bit m_dp = 0;

    always #2.5 clk = ~clk;

    rx_admit_gate #(.FREE_W(FW), .ALLOW_W(AW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .free_bufs_i   (free_bufs),
        .low_mark_i    (low_mark),
        .high_mark_i   (high_mark),
        .allow_i       (allow),
        .sof_i         (sof),
        .eof_i         (eof),
        .good_i        (good),
        .frm_pass_o    (frm_pass),
        .frm_drop_o    (frm_drop),
        .drop_active_o (drop_active)
    );

    always @(posedge clk) begin
        int  hi;
        bit  lowc;
        bit  highc;
        bit  dec;
        int  nst;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_open = 0; m_kept = 0; m_dp = 0;
        end else begin
            hi    = (int'(high_mark) > int'(low_mark)) ? int'(high_mark) : int'(low_mark);
            lowc  = int'(free_bufs) <= int'(low_mark);
            highc = int'(free_bufs) >= hi;
            dec   = (m_st == 1) && eof && m_open && m_kept && good && (m_cnt > 0);
            nst   = m_st;
            if (m_st == 0) begin
                if (lowc) nst = (allow == 0) ? 2 : 1;
            end else if (m_st == 1) begin
                if (highc) nst = 0;
                else if (m_cnt == 0 || (dec && m_cnt == 1)) nst = 2;
            end else begin
                if (highc) nst = 0;
            end
            if (m_st == 0) m_cnt = int'(allow);
            else if (dec) m_cnt = m_cnt - 1;
            if (!m_open && sof) begin
                m_dp = (m_st == 2);
                m_open = 1;
                m_kept = (m_st != 2);
            end else begin
                m_dp = 0;
                if (m_open && eof) begin
                    m_open = 0;
                    m_kept = 0;
                end
            end
            m_st = nst;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        bit ep;
        bit ea;
        ep = m_open && m_kept;
        ea = (m_st == 2);
        if (rst_n) begin
            checks++;
            if (frm_pass !== ep || frm_drop !== m_dp || drop_active !== ea) begin
                errors++;
                $display("FAIL %s model compare: pass/drop/active actual %b%b%b expected %b%b%b at %0t",
                         cur_req, frm_pass, frm_drop, drop_active, ep, m_dp, ea, $time);
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // frame of len cycles between start and end; returns at the negedge after the end edge
    task automatic frame(input bit ok, input int len);
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
        cyc(len - 1);
        eof = 1'b1; good = ok;
        @(negedge clk); eof = 1'b0; good = 1'b0;
    endtask

    initial begin
        cyc(4);
        chk(frm_pass, 1'b0, "R1 pass in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(drop_active, 1'b0, "R1 active after reset");
        chk(frm_drop, 1'b0, "R1 drop after reset");

        // R2: admitted frames under normal occupancy
        cur_req = "R2";
        allow = 16'd2;
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
        chk(frm_pass, 1'b1, "R2 pass after start");
        cyc(2); eof = 1'b1; good = 1'b1;
        chk(frm_pass, 1'b1, "R2 pass in end cycle");
        @(negedge clk); eof = 1'b0;
        chk(frm_pass, 1'b0, "R2 pass cleared after end");

        // R3/R4/R5: ration with allowance 2, a bad frame in between
        cur_req = "R4";
        free_bufs = 6'd8;
        cyc(2);
        chk(drop_active, 1'b0, "R3 ration not shedding");
        frame(1'b1, 3);
        chk(drop_active, 1'b0, "R4 one unit left");
        cur_req = "R5";
        frame(1'b0, 2);
        chk(drop_active, 1'b0, "R5 bad frame spends nothing");
        cur_req = "R4";
        frame(1'b1, 2);
        chk(drop_active, 1'b1, "R4 exhausted enters shed");

        // R6: frame in shed is dropped
        cur_req = "R6";
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
        chk(frm_drop, 1'b1, "R6 drop pulse");
        chk(frm_pass, 1'b0, "R6 no pass");
        @(negedge clk);
        chk(frm_drop, 1'b0, "R6 pulse single cycle");
        eof = 1'b1; good = 1'b1;
        @(negedge clk); eof = 1'b0;

        // R7: recovery at exactly the high level; free one below stays
        cur_req = "R7";
        free_bufs = 6'd19;
        cyc(3);
        chk(drop_active, 1'b1, "R7 below high keeps shed");
        free_bufs = 6'd20;
        cyc(1);
        chk(drop_active, 1'b0, "R7 recover at high");
        free_bufs = 6'd40;

        // R3: zero allowance sheds at once
        cur_req = "R3";
        allow = 16'd0;
        cyc(2);
        free_bufs = 6'd5;
        cyc(1);
        chk(drop_active, 1'b1, "R3 zero allowance sheds");
        free_bufs = 6'd63;
        cyc(1);
        chk(drop_active, 1'b0, "R7 recover from zero case");

        // R9: frame admitted, shedding starts mid-frame, verdict holds
        cur_req = "R9";
        allow = 16'd1;
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
        free_bufs = 6'd0;
        cyc(2);
        eof = 1'b1; good = 1'b1;
        chk(frm_pass, 1'b1, "R9 pass holds in ration");
        @(negedge clk); eof = 1'b0;
        chk(drop_active, 1'b1, "R9 last unit spent by open frame");
        free_bufs = 6'd40;
        cyc(2);

        // R10: start during open frame, end without frame
        cur_req = "R10";
        eof = 1'b1; good = 1'b1;
        @(negedge clk); eof = 1'b0;
        chk(frm_pass, 1'b0, "R10 stray end ignored");
        @(negedge clk); sof = 1'b1;
        @(negedge clk);
        chk(frm_pass, 1'b1, "R10 frame open");
        @(negedge clk); sof = 1'b0;
        chk(frm_drop, 1'b0, "R10 repeated start ignored");
        eof = 1'b1; good = 1'b1;
        @(negedge clk); eof = 1'b0;
        chk(frm_pass, 1'b0, "R10 single frame closed");

        // R8: high below low -> low is effective high
        cur_req = "R8";
        allow = 16'd0;
        low_mark = 6'd10; high_mark = 6'd3;
        free_bufs = 6'd7;
        cyc(2);
        chk(drop_active, 1'b1, "R8 shed with inverted levels");
        free_bufs = 6'd4;
        cyc(2);
        chk(drop_active, 1'b1, "R8 programmed high ignored");
        free_bufs = 6'd11;
        cyc(1);
        chk(drop_active, 1'b0, "R8 recover above low");
        free_bufs = 6'd10;
        cyc(6);
        free_bufs = 6'd40;
        low_mark = 6'd8; high_mark = 6'd20;
        cyc(2);

        // R11/R7: large allowance never exhausts; reload after recovery
        cur_req = "R11";
        allow = 16'hFFFF;
        free_bufs = 6'd2;
        for (int k = 0; k < 4; k++) frame(1'b1, 2);
        chk(drop_active, 1'b0, "R11 large allowance no shed");
        free_bufs = 6'd40;
        cyc(2);
        allow = 16'd3;
        cyc(1);
        free_bufs = 6'd8;
        cur_req = "R7";
        for (int k = 0; k < 2; k++) frame(1'b1, 1);
        chk(drop_active, 1'b0, "R7 reloaded allowance of three");
        frame(1'b1, 1);
        chk(drop_active, 1'b1, "R7 third frame exhausts");
        free_bufs = 6'd40;
        cyc(3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule